// File: doc/BRIEF.md
# Multi-Mode Event Counter and Interval Timer

This block is a 16-bit up-counter that accumulates one chosen kind of event or acts as a free-running timer. The count register is shared, so exactly one source feeds it at any time. A two-bit source field chooses between error strobes, trigger strobes, a transit-time measurement and incoming network messages. Two further control bits choose a slow timebase, which is one tick every 64 system clocks, or a fast timebase, which advances on every system clock. The fast choice overrides everything else.

Software can load any starting value, so that a chosen interval passes before the counter wraps. A wrap from the top value back to zero counts as an overflow. An overflow raises a sticky interrupt request only when both the overflow mask and the global interrupt enable are set. The transit-time mode measures, in system clocks, how long the node's own message takes to return after it was transmitted.

Top module: `evt_ctr`

## Requirements
- R1: After reset the count is 0 and the interrupt request is low.
- R2: The count only moves upward. It wraps from 65535 to 0, and that wrap is an overflow.
- R3: With src=00 and neither timebase selected, each error strobe adds 1 and the other strobes have no effect on the count.
- R4: With src=01, trigger 1 adds 1 and trigger 2 adds 1. Both in the same cycle add 2. Other strobes have no effect.
- R5: With src=10, the first transmit strobe starts a run. The count then rises by 1 on every following clock until the own-receive strobe arrives. That cycle adds nothing and ends the measurement. Further transmit strobes are ignored until the measurement is re-armed.
- R6: With src=11, each network-message strobe adds 1 and the other strobes have no effect.
- R7: When the fast bit is set, the count rises by 1 on every clock. This happens whatever the source field and the slow bit hold.
- R8: When the slow bit is set and the fast bit is clear, the count rises once per 64 clocks. The first rise comes 64 clocks after the clock edge that saw the mode change. A trigger-2 strobe clears the count and restarts the 64-clock period. That clear beats any rise in the same cycle.
- R9: A load strobe sets the count to the load value on the next clock. It beats both a rise and a trigger-2 clear in the same cycle, and it re-arms the transit measurement.
- R10: The interrupt request rises on an overflow only when the mask and enable bits are both 1. It then stays high until an irq_clr strobe arrives. A new overflow in the same cycle as irq_clr wins.
- R11: Any change of the {fast, slow, src} controls from one clock to the next re-arms the transit measurement and restarts the slow period. The count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src | input | 2 | Event source: 00 errors, 01 triggers, 10 transit, 11 network |
| cfg_slow | input | 1 | Select the slow timebase |
| cfg_fast | input | 1 | Select the per-clock timebase (highest priority) |
| cfg_ovf_mask | input | 1 | Let overflow raise the interrupt |
| cfg_irq_en | input | 1 | Global interrupt enable |
| ld_valid | input | 1 | Load strobe |
| ld_value | input | 16 | Value to load |
| irq_clr | input | 1 | Clear the interrupt request |
| ev_err | input | 1 | Error detected strobe |
| ev_trig1 | input | 1 | Trigger 1 strobe |
| ev_trig2 | input | 1 | Trigger 2 strobe |
| ev_tx | input | 1 | Message transmitted strobe |
| ev_own_rx | input | 1 | Own message received back strobe |
| ev_net_rx | input | 1 | Incoming network message strobe |
| count | output | 16 | Current count |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong slow-timebase prescaler shows at the count within 64 clocks, because the first rise after a mode change or a trigger-2 clear comes one edge early or late. A transit state that stays running or stays done gives a wrong delta within a single measurement. A stale transit state is caught when a second transmit after a re-arm does or does not start a new run. Wrong source decoding shows on the first strobe of the sweeps. A wrong interrupt latch shows on the clock edge of the wrap, or on the first clock after irq_clr.

// File: rtl/evt_ctr.sv
module evt_ctr #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_slow,
  input  logic             cfg_fast,
  input  logic             cfg_ovf_mask,
  input  logic             cfg_irq_en,
  input  logic             ld_valid,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             irq_clr,
  input  logic             ev_err,
  input  logic             ev_trig1,
  input  logic             ev_trig2,
  input  logic             ev_tx,
  input  logic             ev_own_rx,
  input  logic             ev_net_rx,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [CNT_W-1:0] count_q;
  logic [3:0]       cfg_now, cfg_q;
  logic [PW-1:0]    pre_q;
  logic             run_q, done_q, irq_q;
  logic             chg, tick, is_slow, is_field, is_transit;
  logic             start, stop, slow_clr, ovf;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;

  assign cfg_now    = {cfg_fast, cfg_slow, cfg_src};
  assign chg        = cfg_now != cfg_q;
  assign tick       = pre_q == PLAST;
  assign is_slow    = !cfg_fast && cfg_slow;
  assign is_field   = !cfg_fast && !cfg_slow;
  assign is_transit = is_field && cfg_src == 2'b10;
  assign start      = is_transit && !run_q && !done_q && ev_tx && !chg;
  assign stop       = run_q && ev_own_rx;
  assign slow_clr   = is_slow && ev_trig2;

  always_comb begin
    inc = 2'd0;
    if (cfg_fast)     inc = 2'd1;
    else if (is_slow) inc = {1'b0, tick && !chg};
    else begin
      case (cfg_src)
        2'b00: inc = {1'b0, ev_err};
        2'b01: inc = {1'b0, ev_trig1} + {1'b0, ev_trig2};
        2'b10: inc = {1'b0, run_q && !stop && !chg};
        default: inc = {1'b0, ev_net_rx};
      endcase
    end
  end

  assign sum = {1'b0, count_q} + {{(CNT_W-1){1'b0}}, inc};
  assign ovf = sum[CNT_W] && !ld_valid && !slow_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      cfg_q   <= '0;
      pre_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      if (ld_valid)      count_q <= ld_value;
      else if (slow_clr) count_q <= '0;
      else               count_q <= sum[CNT_W-1:0];
      if (chg || slow_clr || tick) pre_q <= '0;
      else                         pre_q <= pre_q + 1'b1;
      if (chg || ld_valid) begin
        run_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (start) begin
        run_q  <= 1'b1;
      end else if (stop) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
      if (ovf && cfg_ovf_mask && cfg_irq_en) irq_q <= 1'b1;
      else if (irq_clr)                      irq_q <= 1'b0;
    end
  end

  assign count = count_q;
  assign irq   = irq_q;

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> count == $past(ld_value)); // R9
  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fast && !ld_valid) |=> count == $past(count) + 1'b1); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_field && cfg_src == 2'b00 && !ev_err && !ld_valid) |=> $stable(count)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cfg_ovf_mask && cfg_irq_en)); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R10
  AST_SLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slow && ev_trig2 && !ld_valid) |=> count == '0); // R8
endmodule

// File: tb/evt_ctr_tb.sv
module evt_ctr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic cfg_slow = 0, cfg_fast = 0, cfg_ovf_mask = 0, cfg_irq_en = 0;
  logic ld_valid = 0, irq_clr = 0;
  logic [15:0] ld_value = '0;
  logic ev_err = 0, ev_trig1 = 0, ev_trig2 = 0, ev_tx = 0, ev_own_rx = 0, ev_net_rx = 0;
  logic [15:0] count;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evt_ctr u_dut (.*);

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] v);
    ld_value = v; ld_valid = 1; step(1); ld_valid = 0;
  endtask

  task automatic strobes(logic [5:0] p);
    {ev_net_rx, ev_own_rx, ev_tx, ev_trig2, ev_trig1, ev_err} = p;
    step(1);
    {ev_net_rx, ev_own_rx, ev_tx, ev_trig2, ev_trig1, ev_err} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    @(negedge clk); step(3);
    chk("R1 count", {16'h0, count}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    rst_n = 1; step(2);
    chk("R1 count after release", {16'h0, count}, 0);

    // Sweep every strobe pattern in the three plain field modes (R3, R4, R6)
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      cfg_src = m[1:0]; step(2); load(16'h0); exp = 0;
      for (int p = 0; p < 64; p++) begin
        strobes(p[5:0]);
        if (m == 0) exp += 16'(p[0]);
        if (m == 1) exp += 16'(p[1]) + 16'(p[2]);
        if (m == 3) exp += 16'(p[5]);
        chk(m == 0 ? "R3 error count" : m == 1 ? "R4 trigger count" : "R6 network count",
            {16'h0, count}, {16'h0, exp});
      end
    end

    // R2 wrap, irq with mask and enable (R10)
    cfg_src = 2'b00; cfg_ovf_mask = 1; cfg_irq_en = 1; step(2);
    load(16'hFFFF);
    strobes(6'b000001);
    chk("R2 wrap to zero", {16'h0, count}, 0);
    chk("R10 irq on wrap", {31'h0, irq}, 1);
    step(5);
    chk("R10 irq sticky", {31'h0, irq}, 1);
    irq_clr = 1; step(1); irq_clr = 0;
    chk("R10 irq cleared", {31'h0, irq}, 0);

    // R10 gating: each of mask/enable off blocks irq
    for (int g = 0; g < 3; g++) begin
      cfg_ovf_mask = (g != 0); cfg_irq_en = (g != 1);
      if (g == 2) begin cfg_ovf_mask = 0; cfg_irq_en = 0; end
      load(16'hFFFF); strobes(6'b000001);
      chk("R2 wrap value", {16'h0, count}, 0);
      chk("R10 irq gated off", {31'h0, irq}, 0);
    end

    // R7 fast mode overrides field and slow; R10 overflow timing; set beats clear
    cfg_ovf_mask = 1; cfg_irq_en = 1;
    cfg_fast = 1; cfg_slow = 1; cfg_src = 2'b11;
    ld_value = 16'hFFF0; ld_valid = 1; step(1); ld_valid = 0;
    chk("R9 load in fast", {16'h0, count}, 16'hFFF0);
    step(15);
    chk("R7 fast steps", {16'h0, count}, 16'hFFFF);
    chk("R10 irq before wrap", {31'h0, irq}, 0);
    irq_clr = 1; step(1); irq_clr = 0;
    chk("R7 fast wrap", {16'h0, count}, 0);
    chk("R10 set beats clear", {31'h0, irq}, 1);
    irq_clr = 1; step(1); irq_clr = 0;
    chk("R10 cleared", {31'h0, irq}, 0);
    ld_value = 16'h1234; ld_valid = 1; step(1); ld_valid = 0;
    chk("R9 load beats increment", {16'h0, count}, 16'h1234);
    step(10);
    chk("R7 fast ten more", {16'h0, count}, 16'h123E);

    // R8 slow timebase
    cfg_fast = 0; cfg_slow = 1; load(16'h0);
    // the load edge also saw the mode change
    step(63);
    chk("R8 no tick yet", {16'h0, count}, 0);
    step(1);
    chk("R8 first tick", {16'h0, count}, 1);
    step(64 * 3);
    chk("R8 four ticks", {16'h0, count}, 4);
    step(20);
    strobes(6'b000100);
    chk("R8 trig2 clears", {16'h0, count}, 0);
    step(63);
    chk("R8 restart period", {16'h0, count}, 0);
    step(1);
    chk("R8 tick after clear", {16'h0, count}, 1);
    // clear beats tick: trig2 on the tick cycle
    step(63);
    strobes(6'b000100);
    chk("R8 clear beats tick", {16'h0, count}, 0);
    ld_value = 16'h0055; ld_valid = 1; ev_trig2 = 1; step(1); ld_valid = 0; ev_trig2 = 0;
    chk("R9 load beats clear", {16'h0, count}, 16'h0055);
    strobes(6'b101011);
    chk("R8 event strobes ignored", {16'h0, count}, 16'h0055);

    // R5 transit time
    cfg_slow = 0; cfg_src = 2'b10; step(2); load(16'h0);
    strobes(6'b100111);
    chk("R5 idle ignores others", {16'h0, count}, 0);
    for (int k = 1; k <= 40; k += 13) begin
      load(16'h0);
      strobes(6'b001000);
      step(k - 1);
      strobes(6'b010000);
      chk("R5 transit length", {16'h0, count}, k - 1);
      strobes(6'b001000); step(5);
      chk("R5 done ignores tx", {16'h0, count}, k - 1);
    end
    // R11 mode change re-arms, count kept
    cfg_src = 2'b00; step(2);
    chk("R11 count kept", {16'h0, count}, 39);
    cfg_src = 2'b10; step(2);
    strobes(6'b001000); step(9); strobes(6'b010000);
    chk("R11 rearmed run", {16'h0, count}, 39 + 9);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule